// File: doc/BRIEF.md
# Timer interrupt router with legacy line replacement

This block sits between a bank of timer channels and the interrupt controller. Each channel raises a one-cycle fire strobe when its comparator matches. The block turns each strobe into activity on one of a fixed set of interrupt lines, chosen by that channel's route field. Level-type channels keep their status bit set and their line high until software clears the status. Edge-type channels emit a single-cycle pulse and leave their status clear.

Two legacy interrupt sources also feed the block: a periodic-interval-timer input and a real-time-clock input. Normally they pass through to line 0 and line 8. When the legacy replacement bit is set, channels 0 and 1 take over those two lines and the timer source is told to stand down through the enable output. The real-time-clock level is sampled every cycle, so the line can show the correct value again when legacy mode ends.

Top module: `irq_router`

## Requirements
- R1: After reset, every status bit is 0 and `pit_en` is 1. The stored real-time-clock level is 0, so with `pit_in` low every line is low.
- R2: A fire strobe on an enabled level-type channel (`lvl_type` bit = 1) sets that channel's status bit on the next cycle. The channel's line stays high for as long as the status bit is set.
- R3: A fire strobe on an enabled edge-type channel (`lvl_type` bit = 0) clears that channel's status bit on the next cycle. It also drives the channel's line high for exactly that one cycle.
- R4: A channel is enabled only when both its `ch_en` bit and `glb_en` are 1. While the channel is not enabled, its status bit is 0 from the next cycle on, whether or not it fires, and it drives no line.
- R5: When `clr_we` is 1, each status bit whose `clr_data` bit is 1 is cleared on the next cycle, and the channel's line goes low with it. A `clr_data` bit of 0 leaves its status unchanged. A fire strobe in the same cycle takes precedence over the clear.
- R6: Channel i's route is `route[i*5 +: 5]`, with 32 lines. In legacy mode, channel 0 drives line 0 and channel 1 drives line 8, whatever their route fields hold. All other channels always follow their route field. A line is the OR of everything driving it.
- R7: With legacy mode off, `pit_in` reaches line 0 combinationally. The real-time-clock input reaches line 8 one cycle later, through its stored level.
- R8: The real-time-clock level is stored on every cycle, legacy mode included. In legacy mode neither legacy input reaches a line. When legacy mode ends, line 8 immediately shows the stored level.
- R9: `pit_en` is the registered inverse of `legacy`. It falls one cycle after legacy mode is entered and rises one cycle after it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fire | input | NCH | One-cycle fire strobes, one per channel |
| lvl_type | input | NCH | 1 = level-type channel, 0 = edge-type |
| ch_en | input | NCH | Per-channel interrupt enable |
| route | input | NCH*5 | Packed 5-bit line number per channel |
| glb_en | input | 1 | Global interrupt enable |
| legacy | input | 1 | Legacy replacement mode |
| clr_we | input | 1 | Status clear strobe |
| clr_data | input | NCH | Write-one-to-clear mask |
| pit_in | input | 1 | Legacy interval timer interrupt level |
| rtc_in | input | 1 | Legacy real-time-clock interrupt level |
| irq_out | output | 32 | Interrupt lines |
| status | output | NCH | Per-channel status bits |
| pit_en | output | 1 | Enable for the legacy interval timer |

## Verification
The bench runs a long randomised sweep. It routes channels onto shared lines, including lines 0 and 8, and toggles legacy mode while the real-time-clock input moves.

A design that consulted route fields in legacy mode would light the wrong line. A design that sampled the clock level only outside legacy mode would restore a stale level on exit. The sweep also produces a clear and a fire in the same cycle, which catches a design that lets the clear win. It produces enable drops with a level status pending, which catches a design whose line stays high after its channel is disabled. Back-to-back edge fires are generated too, and they must give continuous pulses and never set the status bit.

// File: rtl/irq_router.sv
module irq_router #(
  parameter int NCH      = 4,
  parameter int NLINES   = 32,
  parameter int PIT_LINE = 0,
  parameter int RTC_LINE = 8,
  localparam int RW      = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    fire,
  input  logic [NCH-1:0]    lvl_type,
  input  logic [NCH-1:0]    ch_en,
  input  logic [NCH*RW-1:0] route,
  input  logic              glb_en,
  input  logic              legacy,
  input  logic              clr_we,
  input  logic [NCH-1:0]    clr_data,
  input  logic              pit_in,
  input  logic              rtc_in,
  output logic [NLINES-1:0] irq_out,
  output logic [NCH-1:0]    status,
  output logic              pit_en
);

  logic [NCH-1:0] st_q, pulse_q;
  logic           rtc_q;
  logic [NCH-1:0] live;

  assign live = ch_en & {NCH{glb_en}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= '0;
      pulse_q <= '0;
      rtc_q   <= 1'b0;
      pit_en  <= 1'b1;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (!live[i])                    st_q[i] <= 1'b0;
        else if (fire[i])                st_q[i] <= lvl_type[i];
        else if (clr_we && clr_data[i])  st_q[i] <= 1'b0;
      end
      pulse_q <= fire & live & ~lvl_type;
      rtc_q   <= rtc_in;
      pit_en  <= ~legacy;
    end
  end

  assign status = st_q;

  logic [RW-1:0] dst [NCH];
  logic [NCH-1:0] drive;

  assign drive = (st_q | pulse_q) & live;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      dst[i] = route[i*RW +: RW];
      if (legacy && i == 0) dst[i] = RW'(PIT_LINE);
      if (legacy && i == 1) dst[i] = RW'(RTC_LINE);
    end
  end

  always_comb begin
    irq_out = '0;
    for (int i = 0; i < NCH; i++)
      if (drive[i]) irq_out[dst[i]] = 1'b1;
    if (!legacy) begin
      irq_out[PIT_LINE] = irq_out[PIT_LINE] | pit_in;
      irq_out[RTC_LINE] = irq_out[RTC_LINE] | rtc_q;
    end
  end

endmodule

module irq_router_chk #(
  parameter int NCH    = 4,
  parameter int NLINES = 32,
  localparam int RW    = $clog2(NLINES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    fire,
  input logic [NCH-1:0]    lvl_type,
  input logic [NCH-1:0]    ch_en,
  input logic              glb_en,
  input logic              legacy,
  input logic              clr_we,
  input logic [NCH-1:0]    clr_data,
  input logic [NCH-1:0]    status,
  input logic              pit_en
);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assert_level_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fire[i] && lvl_type[i] && ch_en[i] && glb_en |=> status[i]);
    assert_edge_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fire[i] && !lvl_type[i] |=> !status[i]);
    assert_disabled_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(ch_en[i] && glb_en) |=> !status[i]);
    assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we && clr_data[i] && !fire[i] |=> !status[i]);
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !fire[i] && !(clr_we && clr_data[i]) && ch_en[i] && glb_en |=> $stable(status[i]));
  end

  assert_pit_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pit_en == !$past(legacy));

endmodule

bind irq_router irq_router_chk #(.NCH(NCH), .NLINES(NLINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .fire(fire), .lvl_type(lvl_type), .ch_en(ch_en),
  .glb_en(glb_en), .legacy(legacy), .clr_we(clr_we), .clr_data(clr_data),
  .status(status), .pit_en(pit_en)
);

// File: tb/sim_irq_router.sv
`timescale 1ns/1ps
module sim_irq_router;
  localparam int NCH = 4, NL = 32, RW = 5;

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] fire = '0, lvl_type = '0, ch_en = '0, clr_data = '0;
  logic [NCH*RW-1:0] route = '0;
  logic glb_en = 0, legacy = 0, clr_we = 0, pit_in = 0, rtc_in = 0;
  logic [NL-1:0] irq_out;
  logic [NCH-1:0] status;
  logic pit_en;

  irq_router #(.NCH(NCH), .NLINES(NL)) u0 (.*);

  always #2.5 clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [NCH-1:0] m_st, m_pl;
  logic m_rtc, m_pit;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [NL-1:0] exp_irq();
    logic [NL-1:0] v = '0;
    for (int i = 0; i < NCH; i++) begin
      int d = route[i*RW +: RW];
      if (legacy && i == 0) d = 0;
      if (legacy && i == 1) d = 8;
      if ((m_st[i] | m_pl[i]) && ch_en[i] && glb_en) v[d] = 1'b1;
    end
    if (!legacy) begin
      v[0] = v[0] | pit_in;
      v[8] = v[8] | m_rtc;
    end
    return v;
  endfunction

  task automatic tick();
    logic [NCH-1:0] ns, np;
    for (int i = 0; i < NCH; i++) begin
      bit en = ch_en[i] & glb_en;
      if (!en) ns[i] = 0;
      else if (fire[i]) ns[i] = lvl_type[i];
      else if (clr_we && clr_data[i]) ns[i] = 0;
      else ns[i] = m_st[i];
      np[i] = fire[i] & en & ~lvl_type[i];
    end
    @(posedge clk); #1;
    if (rst_n) begin
      m_st = ns; m_pl = np; m_rtc = rtc_in; m_pit = ~legacy;
    end
  endtask

  task automatic check_all();
    check(status == m_st, "R2 R3 R4 R5 status", 32'(status), 32'(m_st));
    check(irq_out == exp_irq(), "R6 R7 R8 lines", irq_out, exp_irq());
    check(pit_en == m_pit, "R9 pit_en", 32'(pit_en), 32'(m_pit));
  endtask

  initial begin
    m_st = '0; m_pl = '0; m_rtc = 0; m_pit = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    check(status == '0, "R1 status", 32'(status), 0);
    check(pit_en == 1'b1, "R1 pit_en", 32'(pit_en), 1);
    check(irq_out == '0, "R1 lines", irq_out, 0);

    // directed R2 then R5 on channel 2, routed to line 5
    glb_en = 1; ch_en = '1; lvl_type = 4'b0100; route = {5'd7, 5'd5, 5'd3, 5'd9};
    fire = 4'b0100; tick(); fire = '0;
    check(status[2] && irq_out[5], "R2 level set", {status[2], irq_out[5]}, 2'b11);
    clr_we = 1; clr_data = 4'b0100; tick(); clr_we = 0; clr_data = '0;
    check(!status[2] && !irq_out[5], "R5 clear", {status[2], irq_out[5]}, 0);

    // directed R3 edge pulse on channel 3 -> line 7
    fire = 4'b1000; tick(); fire = '0;
    check(irq_out[7] && !status[3], "R3 pulse", {irq_out[7], status[3]}, 2'b10);
    tick();
    check(!irq_out[7], "R3 pulse ends", irq_out[7], 0);

    // directed R8: rtc stored in legacy, restored on exit
    legacy = 1; rtc_in = 1; tick(); rtc_in = 0; rtc_in = 1; tick();
    check(!irq_out[8], "R8 legacy masks rtc", irq_out[8], 0);
    legacy = 0; #1;
    check(irq_out[8], "R8 restore on exit", irq_out[8], 1);
    check(!pit_en, "R9 pit_en lags", pit_en, 0);

    // directed R4: disable global with level pending
    fire = 4'b0100; tick(); fire = '0;
    glb_en = 0; tick();
    check(!status[2] && !irq_out[5], "R4 global off", {status[2], irq_out[5]}, 0);
    glb_en = 1; rtc_in = 0; tick();

    // sweep
    for (int c = 0; c < 4000; c++) begin
      if (c % 150 == 0) begin
        for (int i = 0; i < NCH; i++) begin
          int r = $urandom_range(0, 5);
          route[i*RW +: RW] = (r == 0) ? 5'd0 : (r == 1) ? 5'd8 : (r == 2) ? 5'd3 : 5'($urandom);
        end
        lvl_type = 4'($urandom);
      end
      fire     = 4'($urandom) & 4'($urandom);
      ch_en    = ~(4'($urandom) & 4'($urandom) & 4'($urandom));
      glb_en   = ($urandom_range(0, 15) != 0);
      if ($urandom_range(0, 40) == 0) legacy = ~legacy;
      clr_we   = $urandom_range(0, 2) == 0;
      clr_data = 4'($urandom);
      pit_in   = $urandom_range(0, 3) == 0;
      if ($urandom_range(0, 5) == 0) rtc_in = ~rtc_in;
      #0.5;
      check(irq_out == exp_irq(), "R6 R7 R8 comb lines", irq_out, exp_irq());
      tick();
      check_all();
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(5 * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog R1 act=0 exp=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule